// File: doc/BRIEF.md
# Addend-Compensated Precision Time Counter

This block keeps a nanosecond time of day for packet timestamping. A reference clock is chosen from four candidates. Each candidate reaches the block as a one-cycle enable in the core clock domain. On every enabled reference cycle, a 32-bit fractional accumulator adds a programmable addend. Each carry out of that accumulator is one nominal tick. The tick rate is therefore the reference rate scaled by addend / 2^32, and software trims the frequency by changing the addend, never by stopping the count.

On every nominal tick, the 64-bit time counter advances by the programmed clock period in nanoseconds. A prescaler emits one strobe for every N ticks. Two independent interval generators count elapsed nanoseconds and emit one-cycle events. A typical use is a once-per-second pulse. Each interval register is programmed with the wanted period minus one clock period. Configuration arrives through a single-cycle write port with a 3-bit register index.

Top module: `ptp_timer`

## Requirements
- R1: While `rst_n` is low and after it rises, `time_ns` is 0, `tick`, `out_strobe`, `pulse_a` and `pulse_b` are 0, and the source select is 1 (system clock).
- R2: Only the enable bit `ref_en[sel]` advances the accumulator, where sel is written at index 0 (0 external precision clock, 1 system clock, 2 first transmit clock, 3 real-time-clock input). Other enable bits have no effect.
- R3: On a clock edge where the selected enable is high, the accumulator becomes (acc + addend) mod 2^32. `tick` is high for the following cycle exactly when that addition carried out of bit 31.
- R4: `time_ns` grows by the period (index 1, bits 7:0) on the same edge that raises `tick`, and holds otherwise.
- R5: A write to index 6 loads `time_ns` with `wr_data` on the next edge. It wins over a simultaneous advance.
- R6: A write to the addend (index 2, bits 31:0) is used from the next edge on and leaves the accumulator value intact.
- R7: With prescale N (index 3, bits 15:0), `out_strobe` rises together with every N-th tick counted from the last prescale write. N = 0 behaves as 1.
- R8: Each interval generator adds the period on every tick. On the tick where the sum reaches interval + period, it raises its pulse for one cycle and keeps the sum minus (interval + period). A write to the interval clears the sum.
- R9: Generator A (index 4) and generator B (index 5) run independently, each with its own interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 4 | Per-source reference cycle enables |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 64 | Write data |
| time_ns | output | 64 | Nanosecond time counter |
| tick | output | 1 | Nominal tick event |
| out_strobe | output | 1 | Prescaled output clock event |
| pulse_a | output | 1 | Interval generator A event |
| pulse_b | output | 1 | Interval generator B event |

## Verification
The hardest case to reach is whether the accumulator survives an addend write. From the ports this shows only as the timing of a later carry. The stimulus therefore loads a quarter-scale addend and allows exactly three enables, which leaves a known residue. It then doubles the addend and gives one more enable: only a preserved residue yields a tick there. The other hard case is a remainder that carries past an interval boundary. An interval of 15 with a 10 ns period drives generator B through alternating three- and two-tick gaps.

// File: rtl/ptp_timer.sv
module ptp_timer #(
  parameter int ACC_W  = 32,
  parameter int TIME_W = 64,
  parameter int PER_W  = 8,
  parameter int PRE_W  = 16,
  parameter int IVL_W  = 32,
  parameter int NSRC   = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   ref_en,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TIME_W-1:0] time_ns,
  output logic              tick,
  output logic              out_strobe,
  output logic              pulse_a,
  output logic              pulse_b
);
  localparam int SEL_W = $clog2(NSRC);
  localparam int CNT_W = IVL_W + 2;
  localparam logic [2:0] A_SRC = 3'd0, A_PER = 3'd1, A_ADD = 3'd2,
                         A_PRE = 3'd3, A_TIME = 3'd6;

  logic [SEL_W-1:0] src;
  logic [PER_W-1:0] period_r;
  logic [ACC_W-1:0] addend, acc;
  logic [PRE_W-1:0] presc_r, pc;
  logic [ACC_W:0]   sum;
  logic             sel_en, carry, time_ld;
  logic [PRE_W-1:0] pre_last;
  logic [1:0]       pls;

  assign sel_en   = ref_en[src];
  assign sum      = {1'b0, acc} + {1'b0, addend};
  assign carry    = sel_en & sum[ACC_W];
  assign time_ld  = wr_en && (wr_addr == A_TIME);
  assign pre_last = (presc_r == '0) ? '0 : presc_r - 1'b1;
  assign pulse_a  = pls[0];
  assign pulse_b  = pls[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src        <= SEL_W'(1);
      period_r   <= '0;
      addend     <= '0;
      presc_r    <= PRE_W'(1);
      acc        <= '0;
      pc         <= '0;
      tick       <= 1'b0;
      out_strobe <= 1'b0;
      time_ns    <= '0;
    end else begin
      tick       <= carry;
      out_strobe <= carry && (pc >= pre_last);
      if (sel_en) acc <= sum[ACC_W-1:0];
      if (time_ld)    time_ns <= wr_data[TIME_W-1:0];
      else if (carry) time_ns <= time_ns + TIME_W'(period_r);
      if (wr_en && wr_addr == A_PRE) pc <= '0;
      else if (carry) pc <= (pc >= pre_last) ? '0 : pc + 1'b1;
      if (wr_en && wr_addr == A_SRC) src      <= wr_data[SEL_W-1:0];
      if (wr_en && wr_addr == A_PER) period_r <= wr_data[PER_W-1:0];
      if (wr_en && wr_addr == A_ADD) addend   <= wr_data[ACC_W-1:0];
      if (wr_en && wr_addr == A_PRE) presc_r  <= wr_data[PRE_W-1:0];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_ivl
    logic [IVL_W-1:0] ivl;
    logic [CNT_W-1:0] cnt, nxt, target;
    logic             fire, ivl_wr;
    assign ivl_wr = wr_en && (wr_addr == 3'(4 + g));
    assign nxt    = cnt + CNT_W'(period_r);
    assign target = CNT_W'(ivl) + CNT_W'(period_r);
    assign fire   = nxt >= target;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ivl    <= '1;
        cnt    <= '0;
        pls[g] <= 1'b0;
      end else begin
        pls[g] <= carry & fire;
        if (ivl_wr) begin
          ivl <= wr_data[IVL_W-1:0];
          cnt <= '0;
        end else if (carry) begin
          cnt <= fire ? nxt - target : nxt;
        end
      end
    end
  end
endmodule

module ptp_timer_chk #(
  parameter int TIME_W = 64,
  parameter int PER_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              out_strobe,
  input logic              pulse_a,
  input logic              pulse_b,
  input logic              sel_en,
  input logic              time_ld,
  input logic [PER_W-1:0]  period_r,
  input logic [TIME_W-1:0] time_ns
);
  // R3
  tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(sel_en));
  // R4
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !$past(time_ld)) |-> time_ns == $past(time_ns) + TIME_W'($past(period_r)));
  // R4
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !$past(time_ld)) |-> $stable(time_ns));
  // R7
  strobe_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> tick);
  // R8
  pulse_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_a || pulse_b) |-> tick);
endmodule

bind ptp_timer ptp_timer_chk #(.TIME_W(TIME_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .out_strobe(out_strobe),
  .pulse_a(pulse_a), .pulse_b(pulse_b), .sel_en(sel_en),
  .time_ld(time_ld), .period_r(period_r), .time_ns(time_ns)
);

// File: tb/sim_ptp_timer.sv
`timescale 1ns/1ps
module sim_ptp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ref_en = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] time_ns;
  logic        tick, out_strobe, pulse_a, pulse_b;

  int checks = 0, fails = 0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  ptp_timer u0 (.clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .time_ns(time_ns), .tick(tick),
    .out_strobe(out_strobe), .pulse_a(pulse_a), .pulse_b(pulse_b));

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  longint unsigned m_src, m_per, m_add, m_pre, m_acc, m_pc, m_time, s, lastpre, n;
  longint unsigned m_ivl [2];
  longint unsigned m_cnt [2];
  bit m_tick, m_strobe, hit;
  bit m_pls [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 1; m_per = 0; m_add = 0; m_pre = 1; m_acc = 0; m_pc = 0; m_time = 0;
      m_tick = 0; m_strobe = 0;
      for (int g = 0; g < 2; g++) begin m_ivl[g] = 64'hFFFF_FFFF; m_cnt[g] = 0; m_pls[g] = 0; end
    end else begin
      hit = 0;
      if (ref_en[m_src]) begin
        s = m_acc + m_add;
        m_acc = s % 64'h1_0000_0000;
        hit = (s >= 64'h1_0000_0000);
      end
      lastpre = (m_pre == 0) ? 0 : m_pre - 1;
      m_tick = hit;
      m_strobe = hit && (m_pc >= lastpre);
      for (int g = 0; g < 2; g++) m_pls[g] = 0;
      if (hit) begin
        m_time = m_time + m_per;
        m_pc = (m_pc >= lastpre) ? 0 : m_pc + 1;
        for (int g = 0; g < 2; g++) begin
          n = m_cnt[g] + m_per;
          m_pls[g] = (n >= m_ivl[g] + m_per);
          m_cnt[g] = m_pls[g] ? n - (m_ivl[g] + m_per) : n;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_src = wr_data[1:0];
          3'd1: m_per = wr_data[7:0];
          3'd2: m_add = wr_data[31:0];
          3'd3: begin m_pre = wr_data[15:0]; m_pc = 0; end
          3'd4: begin m_ivl[0] = wr_data[31:0]; m_cnt[0] = 0; end
          3'd5: begin m_ivl[1] = wr_data[31:0]; m_cnt[1] = 0; end
          3'd6: m_time = wr_data;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk("R4 time", time_ns, m_time);
      chk("R3 tick", tick, m_tick);
      chk("R7 strobe", out_strobe, m_strobe);
      chk("R8 pulse_a", pulse_a, m_pls[0]);
      chk("R9 pulse_b", pulse_b, m_pls[1]);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cnt_t, cnt_s, cnt_a, cnt_b;
    logic [3:0] lfsr = 4'b1001;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 time", time_ns, 0);
    chk("R1 events", {tick, out_strobe, pulse_a, pulse_b}, 0);
    @(negedge clk); rst_n = 1'b1; model_on = 1'b1;
    @(negedge clk);
    chk("R1 time after release", time_ns, 0);

    // R6: residue kept across addend write
    wr(3'd1, 64'd10);
    wr(3'd2, 64'h4000_0000);
    ref_en = 4'b0010;
    repeat (3) @(negedge clk);
    ref_en = 4'b0000;
    wr(3'd2, 64'h8000_0000);
    ref_en = 4'b0010;
    @(negedge clk);
    ref_en = 4'b0000;
    chk("R6 carry from kept residue", tick, 1);
    chk("R6 time advanced once", time_ns, 10);
    @(negedge clk);

    // R2: unselected enable ignored, then select source 0
    cnt_t = 0; ref_en = 4'b1101;
    repeat (10) begin @(negedge clk); if (tick) cnt_t++; end
    chk("R2 unselected ignored", cnt_t, 0);
    chk("R2 time unchanged", time_ns, 10);
    wr(3'd0, 64'd0);
    cnt_t = 0; ref_en = 4'b0001;
    repeat (10) begin @(negedge clk); if (tick) cnt_t++; end
    chk("R2 source 0 ticks", cnt_t, 5);

    // R5: load wins over advance
    ref_en = 4'b1111;
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd6; wr_data = 64'h0000_1234_0000_0000;
    @(negedge clk); wr_en = 1'b0;
    chk("R5 load", time_ns, 64'h0000_1234_0000_0000);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd6; wr_data = 64'h77;
    @(negedge clk); wr_en = 1'b0;
    chk("R5 load again", time_ns, 64'h77);

    // R7: prescale 0 behaves as 1, then 3
    wr(3'd3, 64'd0);
    repeat (20) begin @(negedge clk); chk("R7 N=0 strobe equals tick", out_strobe, tick); end
    ref_en = 4'b0000;
    wr(3'd3, 64'd3);
    ref_en = 4'b1111; cnt_t = 0; cnt_s = 0;
    repeat (60) begin @(negedge clk); if (tick) cnt_t++; if (out_strobe) cnt_s++; end
    chk("R7 ticks in window", cnt_t, 30);
    chk("R7 strobes every third tick", cnt_s, 10);

    // R8 / R9: two generators with different intervals
    ref_en = 4'b0000;
    wr(3'd4, 64'd30);
    wr(3'd5, 64'd15);
    ref_en = 4'b1111; cnt_a = 0; cnt_b = 0;
    repeat (80) begin @(negedge clk); if (pulse_a) cnt_a++; if (pulse_b) cnt_b++; end
    chk("R8 generator A count", cnt_a, 10);
    chk("R9 generator B count", cnt_b, 16);

    // fractional addend with irregular reference, once-per-second interval
    ref_en = 4'b0000;
    wr(3'd2, 64'h9999_99A4);
    wr(3'd4, 64'd999_999_990);
    wr(3'd0, 64'd2);
    repeat (2000) begin
      @(negedge clk);
      lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      ref_en = lfsr;
    end
    wr(3'd0, 64'd3);
    repeat (500) begin
      @(negedge clk);
      lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      ref_en = lfsr;
    end
    ref_en = 4'b0000;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule